// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block sits between a processor-side request port and a slower main-memory port. It keeps a small direct-mapped cache. Each line holds one block of several words, a tag naming the memory block that occupies the line, a valid flag and a modified flag. A hit is answered from the cache and never touches memory. A miss first brings the whole block in, one word per memory beat, and only then completes the request.

A static mode input picks the write policy, and it is changed only while reset is held. In write-back mode a write stays in the cache and marks the line modified. A modified line that is about to be replaced is copied out to memory before its slot is refilled. In write-through mode every write goes to memory, no line is ever marked modified, and a write that misses does not allocate a line. Both ports use a valid/ready request handshake. Requests are served strictly one at a time.

Word addresses split into three fields. The lowest `OFF_W` bits select the word in the block, the next `IDX_W` bits select the line, and the remaining high bits form the tag. With the default configuration the address is 8 bits: offset [1:0], line [3:2] and tag [7:4].

Top module: `blkc_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `cpu_req_ready` is 1 and `mem_req_valid` and `cpu_rsp_valid` are 0. Reset clears every valid and modified flag, so the first access to any line after reset is a miss.
- R2: A read hit returns the stored word on `cpu_rsp_rdata` with `cpu_rsp_valid` high. No memory request is made during the operation, and no memory request is ever made while `cpu_req_ready` is high.
- R3: A read miss issues exactly one memory read per word of the block. The line then holds the new block, and the response carries the requested word from that block.
- R4: The memory transfers of a block refill or a block copy-out run in ascending word order, starting at offset 0. The memory address is {tag, line, offset}.
- R5: In write-back mode, a write hit updates only the cache, with no memory traffic, and marks the line modified. A later read returns the written data.
- R6: In write-back mode, a write miss fetches the block from memory, merges the write data into it and marks the line modified.
- R7: A miss that replaces a valid, modified line first writes all words of the old block to memory at the old tag's addresses, then refills. A miss that replaces a clean or invalid line writes nothing.
- R8: In write-through mode, each write makes exactly one memory write of its address and data and no memory read, a write miss does not allocate a line, and line replacement never writes back.
- R9: From the cycle after a request is accepted until its response cycle, `cpu_req_ready` stays 0. Every request, read or write, ends with a single-cycle `cpu_rsp_valid` pulse.
- R10: A memory request that is not accepted keeps `mem_req_valid` high and holds its address, direction and write data unchanged until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wt_mode | input | 1 | 1 selects write-through, 0 write-back; static outside reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_write | input | 1 | 1 for write, 0 for read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Read data (write data echoed on writes) |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for memory write, 0 for read |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rsp_valid | input | 1 | Read data beat from memory |
| mem_rsp_rdata | input | DATA_W | Read data word |

## Verification
The bench sweeps every address of the small default configuration in both modes. It uses strided write orders so that blocks keep colliding in the same line, and it predicts each operation's memory traffic from its own model of tags and flags. If the line were not marked modified, the old block would be dropped silently on replacement and the final memory image would disagree. A clean victim that was still written back would show extra memory writes. A refill started at the requested offset, rather than at offset 0, would show a word out of order. A write-through miss that allocated a line would show unexpected memory reads. Memory ready is throttled so that a request dropped or changed while stalled becomes visible.

// File: rtl/blkc_pkg.sv
package blkc_pkg;

    parameter int unsigned ADDR_W = 8;
    parameter int unsigned DATA_W = 16;
    parameter int unsigned LINES  = 4;
    parameter int unsigned WORDS  = 4;

    localparam int unsigned OFF_W = $clog2(WORDS);
    localparam int unsigned IDX_W = $clog2(LINES);
    localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_THRU
    } ctl_state_e;

    typedef struct packed {
        logic  write;
        addr_t addr;
        data_t wdata;
    } cpu_req_t;

    function automatic off_t addr_off(input addr_t a);
        return a[OFF_W-1:0];
    endfunction

    function automatic idx_t addr_idx(input addr_t a);
        return a[OFF_W +: IDX_W];
    endfunction

    function automatic tag_t addr_tag(input addr_t a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction

endpackage

// File: rtl/blkc_tag_store.sv
module blkc_tag_store
    import blkc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  idx_t idx,
    input  logic fill_done,
    input  tag_t fill_tag,
    input  logic mark_dirty,
    output tag_t line_tag,
    output logic line_valid,
    output logic line_dirty
);

    tag_t             tag_q [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;

    for (genvar ln = 0; ln < LINES; ln++) begin : g_line
        logic sel;
        assign sel = (idx == idx_t'(ln));

        always_ff @(posedge clk) begin
            if (sel && fill_done) begin
                tag_q[ln] <= fill_tag;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[ln] <= 1'b0;
                dirty_q[ln] <= 1'b0;
            end else if (sel && fill_done) begin
                valid_q[ln] <= 1'b1;
                dirty_q[ln] <= 1'b0;
            end else if (sel && mark_dirty) begin
                dirty_q[ln] <= 1'b1;
            end
        end
    end

    assign line_tag   = tag_q[idx];
    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];

endmodule

// File: rtl/blkc_data_store.sv
module blkc_data_store
    import blkc_pkg::*;
(
    input  logic  clk,
    input  logic  we,
    input  idx_t  idx,
    input  off_t  woff,
    input  data_t wdata,
    input  off_t  roff,
    output data_t rdata
);

    localparam int unsigned ENTRIES = LINES * WORDS;

    data_t store_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[{idx, woff}] <= wdata;
        end
    end

    assign rdata = store_q[{idx, roff}];

endmodule

// File: rtl/blkc_top.sv
module blkc_top
    import blkc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wt_mode,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata
);

    localparam off_t LAST_OFF = off_t'(WORDS - 1);

    ctl_state_e state_q;
    cpu_req_t   req_q;
    off_t       cnt_q;
    logic       rsp_valid_q;
    data_t      rsp_data_q;

    tag_t  req_tag;
    idx_t  req_idx;
    off_t  req_off;
    tag_t  line_tag;
    logic  line_valid;
    logic  line_dirty;
    logic  hit;
    logic  fill_done;
    logic  mark_dirty;
    logic  st_we;
    off_t  st_woff;
    off_t  st_roff;
    data_t st_wdata;
    data_t st_rdata;

    assign req_tag = addr_tag(req_q.addr);
    assign req_idx = addr_idx(req_q.addr);
    assign req_off = addr_off(req_q.addr);
    assign hit     = line_valid && (line_tag == req_tag);

    // Line bookkeeping: a refill completes on the last memory beat.
    assign fill_done  = (state_q == ST_FILL_WAIT) && mem_rsp_valid && (cnt_q == LAST_OFF);
    assign mark_dirty = (state_q == ST_LOOKUP) && hit && req_q.write && !wt_mode;

    blkc_tag_store u_tags (
        .clk        (clk),
        .rst        (rst),
        .idx        (req_idx),
        .fill_done  (fill_done),
        .fill_tag   (req_tag),
        .mark_dirty (mark_dirty),
        .line_tag   (line_tag),
        .line_valid (line_valid),
        .line_dirty (line_dirty)
    );

    // Data array: refill beats and write hits share the single write port.
    always_comb begin
        st_we    = 1'b0;
        st_woff  = req_off;
        st_wdata = req_q.wdata;
        if (state_q == ST_FILL_WAIT) begin
            st_we    = mem_rsp_valid;
            st_woff  = cnt_q;
            st_wdata = mem_rsp_rdata;
        end else if (state_q == ST_LOOKUP) begin
            st_we    = hit && req_q.write;
        end
    end

    assign st_roff = (state_q == ST_EVICT) ? cnt_q : req_off;

    blkc_data_store u_data (
        .clk   (clk),
        .we    (st_we),
        .idx   (req_idx),
        .woff  (st_woff),
        .wdata (st_wdata),
        .roff  (st_roff),
        .rdata (st_rdata)
    );

    // Control sequence.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            req_q       <= '0;
            cnt_q       <= '0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_req_valid) begin
                        req_q.write <= cpu_req_write;
                        req_q.addr  <= cpu_req_addr;
                        req_q.wdata <= cpu_req_wdata;
                        state_q     <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (req_q.write && wt_mode) begin
                        state_q <= ST_THRU;
                    end else if (hit) begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= req_q.write ? req_q.wdata : st_rdata;
                        state_q     <= ST_IDLE;
                    end else begin
                        cnt_q   <= '0;
                        state_q <= (line_valid && line_dirty) ? ST_EVICT : ST_FILL_REQ;
                    end
                end
                ST_EVICT: begin
                    if (mem_req_ready) begin
                        if (cnt_q == LAST_OFF) begin
                            cnt_q   <= '0;
                            state_q <= ST_FILL_REQ;
                        end else begin
                            cnt_q <= cnt_q + off_t'(1);
                        end
                    end
                end
                ST_FILL_REQ: begin
                    if (mem_req_ready) begin
                        state_q <= ST_FILL_WAIT;
                    end
                end
                ST_FILL_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (cnt_q == LAST_OFF) begin
                            cnt_q   <= '0;
                            state_q <= ST_LOOKUP;
                        end else begin
                            cnt_q   <= cnt_q + off_t'(1);
                            state_q <= ST_FILL_REQ;
                        end
                    end
                end
                ST_THRU: begin
                    if (mem_req_ready) begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= req_q.wdata;
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory port.
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = req_q.addr;
        mem_req_wdata = req_q.wdata;
        unique case (state_q)
            ST_EVICT: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = {line_tag, req_idx, cnt_q};
                mem_req_wdata = st_rdata;
            end
            ST_FILL_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = {req_tag, req_idx, cnt_q};
            end
            ST_THRU: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
            end
            default: ;
        endcase
    end

    assign cpu_req_ready = (state_q == ST_IDLE);
    assign cpu_rsp_valid = rsp_valid_q;
    assign cpu_rsp_rdata = rsp_data_q;

endmodule

// File: rtl/blkc_checker.sv
module blkc_checker
    import blkc_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  wt_mode,
    input logic  cpu_req_valid,
    input logic  cpu_req_ready,
    input logic  cpu_rsp_valid,
    input logic  mem_req_valid,
    input logic  mem_req_ready,
    input logic  mem_req_write,
    input addr_t mem_req_addr,
    input data_t mem_req_wdata
);

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cpu_req_ready && !mem_req_valid && !cpu_rsp_valid));

    assert_idle_no_mem_R2: assert property (@(posedge clk) disable iff (rst)
        cpu_req_ready |-> !mem_req_valid);

    assert_thru_single_R8: assert property (@(posedge clk) disable iff (rst)
        (wt_mode && mem_req_valid && mem_req_write && mem_req_ready) |=> cpu_rsp_valid);

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        cpu_rsp_valid |=> !cpu_rsp_valid);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
             && $stable(mem_req_wdata)));

endmodule

bind blkc_top blkc_checker u_blkc_checker (
    .clk           (clk),
    .rst           (rst),
    .wt_mode       (wt_mode),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_rsp_valid (cpu_rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata)
);

// File: tb/test_blkc_top.sv
module test_blkc_top;
    import blkc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int SPACE      = 1 << ADDR_W;
    localparam int WD_LIMIT   = 150000;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  wt_mode = 1'b0;
    logic  cpu_req_valid = 1'b0;
    logic  cpu_req_ready;
    logic  cpu_req_write = 1'b0;
    addr_t cpu_req_addr = '0;
    data_t cpu_req_wdata = '0;
    logic  cpu_rsp_valid;
    data_t cpu_rsp_rdata;
    logic  mem_req_valid;
    logic  mem_req_ready = 1'b0;
    logic  mem_req_write;
    addr_t mem_req_addr;
    data_t mem_req_wdata;
    logic  mem_rsp_valid = 1'b0;
    data_t mem_rsp_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blkc_top i_blkc_top (
        .clk           (clk),
        .rst           (rst),
        .wt_mode       (wt_mode),
        .cpu_req_valid (cpu_req_valid),
        .cpu_req_ready (cpu_req_ready),
        .cpu_req_write (cpu_req_write),
        .cpu_req_addr  (cpu_req_addr),
        .cpu_req_wdata (cpu_req_wdata),
        .cpu_rsp_valid (cpu_rsp_valid),
        .cpu_rsp_rdata (cpu_rsp_rdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata)
    );

    int errors = 0;
    int checks = 0;

    // Bench memory and processor-visible reference image.
    data_t mem_img [SPACE];
    data_t ref_img [SPACE];

    // Bench line model.
    logic  m_valid [LINES];
    tag_t  m_tag   [LINES];
    logic  m_dirty [LINES];

    int n_rd = 0;
    int n_wr = 0;
    int ord_bad = 0;
    int hs_bad = 0;
    int cyc = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model: one-cycle read latency, throttled ready.
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (!rst && mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                if (!wt_mode && (int'(addr_off(mem_req_addr)) != (n_wr % WORDS))) ord_bad++;
                mem_img[mem_req_addr] = mem_req_wdata;
                n_wr++;
            end else begin
                if (int'(addr_off(mem_req_addr)) != (n_rd % WORDS)) ord_bad++;
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem_img[mem_req_addr];
                n_rd++;
            end
        end
    end

    // Ready throttle and handshake monitor, away from the active edge.
    logic  prev_stall = 1'b0;
    addr_t prev_addr = '0;
    always @(negedge clk) begin
        cyc++;
        if (!rst && prev_stall && (!mem_req_valid || mem_req_addr != prev_addr)) hs_bad++;
        mem_req_ready = ((cyc % 3) != 1);
        prev_stall = !rst && mem_req_valid && !mem_req_ready;
        prev_addr  = mem_req_addr;
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cpu_req_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(cpu_req_ready === 1'b1, "R1 ready in reset", int'(cpu_req_ready), 1);
        check(mem_req_valid === 1'b0, "R1 mem idle in reset", int'(mem_req_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(cpu_req_ready === 1'b1 && cpu_rsp_valid === 1'b0,
              "R1 idle after reset", int'({cpu_req_ready, cpu_rsp_valid}), 2);
        check(mem_req_valid === 1'b0, "R1 mem idle after reset", int'(mem_req_valid), 0);
        for (int l = 0; l < LINES; l++) begin
            m_valid[l] = 1'b0;
            m_dirty[l] = 1'b0;
            m_tag[l]   = '0;
        end
    endtask

    task automatic cpu_op(input logic wr, input addr_t a, input data_t d,
                          output data_t rd, output bit busy_bad);
        busy_bad = 1'b0;
        n_rd = 0;
        n_wr = 0;
        ord_bad = 0;
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = a;
        cpu_req_wdata = d;
        while (cpu_req_ready !== 1'b1) @(negedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        while (cpu_rsp_valid !== 1'b1) begin
            if (cpu_req_ready !== 1'b0) busy_bad = 1'b1;
            @(negedge clk);
        end
        rd = cpu_rsp_rdata;
        @(negedge clk);
    endtask

    task automatic do_op(input logic wr, input addr_t a, input data_t d);
        idx_t  li = addr_idx(a);
        tag_t  tg = addr_tag(a);
        logic  hit = m_valid[li] && (m_tag[li] == tg);
        int    exp_rd;
        int    exp_wr;
        data_t got;
        bit    busy_bad;
        string rtag;
        if (!wt_mode) begin
            exp_rd = hit ? 0 : WORDS;
            exp_wr = (!hit && m_valid[li] && m_dirty[li]) ? WORDS : 0;
            rtag   = hit ? (wr ? "R5" : "R2") : (wr ? "R6" : "R3");
        end else begin
            exp_wr = wr ? 1 : 0;
            exp_rd = (!wr && !hit) ? WORDS : 0;
            rtag   = wr ? "R8" : (hit ? "R2" : "R3");
        end
        cpu_op(wr, a, d, got, busy_bad);
        if (!wr) check(got === ref_img[a], {rtag, " read data"}, int'(got), int'(ref_img[a]));
        check(n_rd == exp_rd, {rtag, " memory reads"}, n_rd, exp_rd);
        check(n_wr == exp_wr, wt_mode ? "R8 memory writes" : "R7 memory writes", n_wr, exp_wr);
        check(ord_bad == 0, "R4 ascending transfer order", ord_bad, 0);
        check(!busy_bad, "R9 ready low while busy", int'(busy_bad), 0);
        if (wr) ref_img[a] = d;
        if (!wt_mode) begin
            if (!hit) begin
                m_valid[li] = 1'b1;
                m_tag[li]   = tg;
                m_dirty[li] = 1'b0;
            end
            if (wr) m_dirty[li] = 1'b1;
        end else if (!wr && !hit) begin
            m_valid[li] = 1'b1;
            m_tag[li]   = tg;
            m_dirty[li] = 1'b0;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d cycles", WD_LIMIT, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int bad;
        for (int a = 0; a < SPACE; a++) begin
            mem_img[a] = data_t'(a * 37 + 5);
            ref_img[a] = mem_img[a];
        end
        do_reset();

        // Write-back: ascending read sweep (one miss per block, then hits).
        for (int a = 0; a < SPACE; a++) do_op(1'b0, addr_t'(a), '0);
        // Write-back: strided writes force conflicting lines and dirty evictions.
        for (int i = 0; i < SPACE; i++) begin
            int a = (i * 5) % SPACE;
            do_op(1'b1, addr_t'(a), data_t'((a * 91) ^ 16'h5A5A));
        end
        // Write-back: descending read-back.
        for (int a = SPACE - 1; a >= 0; a--) do_op(1'b0, addr_t'(a), '0);
        // Interleaved write/read on two conflicting blocks.
        for (int i = 0; i < 16; i++) begin
            addr_t a = addr_t'((i % 2) * (LINES * WORDS) + (i % WORDS));
            do_op(1'b1, a, data_t'(16'hC000 + i));
            do_op(1'b0, a ^ addr_t'(LINES * WORDS), '0);
        end
        // Memory must hold every block that is not still modified in the cache.
        bad = 0;
        for (int a = 0; a < SPACE; a++) begin
            idx_t li = addr_idx(addr_t'(a));
            if (!(m_valid[li] && m_tag[li] == addr_tag(addr_t'(a)) && m_dirty[li]))
                if (mem_img[a] !== ref_img[a]) bad++;
        end
        check(bad == 0, "R7 written-back memory image", bad, 0);

        // Write-through: modified data held only in the cache is lost at reset.
        for (int a = 0; a < SPACE; a++) ref_img[a] = mem_img[a];
        @(negedge clk);
        rst = 1'b1;
        wt_mode = 1'b1;
        do_reset();
        for (int a = 0; a < SPACE; a += WORDS) do_op(1'b0, addr_t'(a), '0);
        for (int i = 0; i < SPACE; i++) begin
            int a = (i * 3) % SPACE;
            do_op(1'b1, addr_t'(a), data_t'(a * 13 + 16'h0100));
        end
        for (int a = 0; a < SPACE; a++) do_op(1'b0, addr_t'(a), '0);
        bad = 0;
        for (int a = 0; a < SPACE; a++) if (mem_img[a] !== ref_img[a]) bad++;
        check(bad == 0, "R8 write-through memory image", bad, 0);

        check(hs_bad == 0, "R10 memory request held while stalled", hs_bad, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule